// File: doc/BRIEF.md
# Bank Register Decode Qualifier

This block is the bank-control front end for an 8-bit processor that reaches a 1 MB physical space through 64 KB banks. It holds two 4-bit bank registers that the processor reaches at CPU addresses 0x0000 and 0x0001. The register at 0x0000 is the execution bank. It places every ordinary cycle: opcode fetches, operand fetches, pointer reads and plain data accesses. The register at 0x0001 is the far-data bank. It places only the data cycle of an indirect-indexed (Y) instruction, which is the only way to reach memory outside the current bank.

Register decode is qualified by the cycle type. During an indirect-Y data cycle the two low addresses do not select the registers. That access goes to memory in the far-data bank like any other byte, so every bank keeps all 65,536 of its bytes usable. The core marks this cycle with a per-cycle flag. A sync (opcode fetch) cycle always counts as an ordinary cycle, even if the flag is set.

Top module: `bank_ctrl_front`

## Requirements
- R1: After a synchronous active-low reset, both bank registers hold 0xF. Ordinary cycles therefore map to phys_addr[19:16] = 0xF, and reads of either register return 0x0F.
- R2: phys_addr[15:0] always equals cpu_addr[15:0], and phys_addr[19:16] equals the active bank value.
- R3: reg_sel is 1 exactly when cpu_addr is 0x0000 or 0x0001 and the cycle is not an indirect-Y data cycle.
- R4: An indirect-Y data cycle is one with ind_y_data=1 and cpu_sync=0. It takes phys_addr[19:16] from the far-data bank (0x0001). Every other cycle takes it from the execution bank (0x0000).
- R5: When cpu_sync=1, the cycle is ordinary whatever the value of ind_y_data. It uses the execution bank, and reg_sel follows the R3 address rule.
- R6: A cycle with reg_sel=1 and cpu_rnw=0 loads cpu_wdata[3:0] into the execution bank (cpu_addr[0]=0) or into the far-data bank (cpu_addr[0]=1). The new value applies from the next cycle on.
- R7: A write during an indirect-Y data cycle to 0x0000 or 0x0001 does not change either register. That write goes to memory, with mem_cs=1.
- R8: reg_rdata equals {4'b0000, bank} of the addressed register when reg_sel=1 and cpu_rnw=1. In every other cycle it is 0x00.
- R9: mem_cs is 1 exactly when reg_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU logical address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_sync | input | 1 | Opcode fetch cycle marker |
| ind_y_data | input | 1 | Marks the data cycle of an indirect-Y instruction |
| phys_addr | output | 20 | Physical address {bank, cpu_addr} |
| reg_sel | output | 1 | Bank register selected this cycle |
| mem_cs | output | 1 | Memory chip select |
| reg_rdata | output | 8 | Register read data, zero when not reading a register |

## Verification
The assertions check four things on every cycle. reg_sel only accompanies the two low addresses and never an indirect-Y data cycle. reg_sel and mem_cs are never both active. A qualified write lands in the addressed register one edge later, and every other cycle leaves that register unchanged. Other behaviour is visible only in the bench's scenarios, because each needs a sequence of cycles. These are:
- the reset value;
- the choice of bank for each cycle type, including a sync cycle with the flag set;
- an indirect-Y write to 0x0000 that must reach memory and leave both registers intact, shown by later reads.

// File: rtl/bankq_pkg.sv
// Package: shared cycle classification for the bank decode front end.
// Assumes: one CPU bus cycle per clock.
package bankq_pkg;
    typedef enum logic [1:0] {
        CYC_ORDINARY = 2'd0,
        CYC_FETCH    = 2'd1,
        CYC_FAR_DATA = 2'd2
    } cyc_kind_t;

    localparam int unsigned NUM_BANK_REGS = 2;
    localparam int unsigned EXEC_IDX      = 0;
    localparam int unsigned FAR_IDX       = 1;
endpackage

// File: rtl/bankq_cycle_qual.sv
// Module: classifies the current bus cycle and qualifies register decode.
// Assumes: cpu_sync and ind_y_data are valid for the whole cycle. A sync
// cycle is never treated as a far-data cycle.
module bankq_cycle_qual
    import bankq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_sync,
    input  logic              ind_y_data,
    output logic              use_far,
    output logic              reg_sel,
    output logic              reg_idx
);
    cyc_kind_t kind;
    logic      low_pair;

    // Purpose: decide the cycle type; sync wins over the indirect-Y flag.
    always_comb begin
        if (cpu_sync)        kind = CYC_FETCH;
        else if (ind_y_data) kind = CYC_FAR_DATA;
        else                 kind = CYC_ORDINARY;
    end

    // Purpose: spot the two-byte register window at the bottom of the map.
    always_comb begin
        low_pair = (cpu_addr[ADDR_W-1:1] == '0);
    end

    // Purpose: drive the bank choice and the qualified register select.
    always_comb begin
        use_far = (kind == CYC_FAR_DATA);
        reg_sel = low_pair && (kind != CYC_FAR_DATA);
        reg_idx = cpu_addr[0];
    end

    assert_sel_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (cpu_addr[ADDR_W-1:1] == '0));

    assert_sel_not_far_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> !(ind_y_data && !cpu_sync));

    assert_sync_ordinary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sync |-> !use_far);
endmodule

// File: rtl/bankq_regfile.sv
// Module: holds the bank registers and offers one combinational read port.
// Assumes: wr_en is already qualified by the decoder. Writes land on the
// clock edge that ends the write cycle.
module bankq_regfile
    import bankq_pkg::*;
#(
    parameter int unsigned        BANK_W     = 4,
    parameter logic [BANK_W-1:0]  RESET_BANK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_idx,
    input  logic [BANK_W-1:0] wr_data,
    input  logic              rd_idx,
    output logic [BANK_W-1:0] exec_bank,
    output logic [BANK_W-1:0] far_bank,
    output logic [BANK_W-1:0] rd_bank
);
    logic [BANK_W-1:0] bank_q [NUM_BANK_REGS];

    for (genvar i = 0; i < NUM_BANK_REGS; i++) begin : g_reg
        // Purpose: reset or load one bank register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[i] <= RESET_BANK;
            else if (wr_en && (wr_idx == i[0]))
                bank_q[i] <= wr_data;
        end

        assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == i[0])) |=> (bank_q[i] == $past(wr_data)));

        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_idx == i[0])) |=> $stable(bank_q[i]));
    end

    // Purpose: expose both banks and the addressed one for reads.
    always_comb begin
        exec_bank = bank_q[EXEC_IDX];
        far_bank  = bank_q[FAR_IDX];
        rd_bank   = bank_q[rd_idx];
    end
endmodule

// File: rtl/bankq_addr_map.sv
// Module: forms the physical address from the active bank and CPU address.
// Assumes: use_far is already resolved for this cycle.
module bankq_addr_map #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned BANK_W = 4,
    localparam int unsigned PHYS_W = ADDR_W + BANK_W
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BANK_W-1:0] exec_bank,
    input  logic [BANK_W-1:0] far_bank,
    input  logic              use_far,
    output logic [PHYS_W-1:0] phys_addr
);
    // Purpose: pick the bank and concatenate it above the CPU address.
    always_comb begin
        phys_addr = {(use_far ? far_bank : exec_bank), cpu_addr};
    end
endmodule

// File: rtl/bank_ctrl_front.sv
// Module: bank-control front end. It joins the cycle qualifier, the register
// file and the address map, and drives the memory select and read data.
// Assumes: one bus cycle per clock; cpu_rnw is valid for the whole cycle.
module bank_ctrl_front #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned BANK_W     = 4,
    parameter int unsigned DATA_W     = 8,
    parameter logic [BANK_W-1:0] RESET_BANK = '1,
    localparam int unsigned PHYS_W    = ADDR_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rnw,
    input  logic              cpu_sync,
    input  logic              ind_y_data,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              reg_sel,
    output logic              mem_cs,
    output logic [DATA_W-1:0] reg_rdata
);
    logic              use_far;
    logic              reg_idx;
    logic              wr_en;
    logic [BANK_W-1:0] exec_bank;
    logic [BANK_W-1:0] far_bank;
    logic [BANK_W-1:0] rd_bank;
    logic              unused_wdata_hi;

    bankq_cycle_qual #(.ADDR_W(ADDR_W)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_sync   (cpu_sync),
        .ind_y_data (ind_y_data),
        .use_far    (use_far),
        .reg_sel    (reg_sel),
        .reg_idx    (reg_idx)
    );

    // Purpose: qualify register writes with select and direction.
    always_comb begin
        wr_en = reg_sel && !cpu_rnw;
    end

    assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:BANK_W];

    bankq_regfile #(.BANK_W(BANK_W), .RESET_BANK(RESET_BANK)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (reg_idx),
        .wr_data   (cpu_wdata[BANK_W-1:0]),
        .rd_idx    (reg_idx),
        .exec_bank (exec_bank),
        .far_bank  (far_bank),
        .rd_bank   (rd_bank)
    );

    bankq_addr_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_map (
        .cpu_addr  (cpu_addr),
        .exec_bank (exec_bank),
        .far_bank  (far_bank),
        .use_far   (use_far),
        .phys_addr (phys_addr)
    );

    // Purpose: steer memory select and zero-extended register read data.
    always_comb begin
        mem_cs    = !reg_sel;
        reg_rdata = (reg_sel && cpu_rnw) ? {{(DATA_W-BANK_W){1'b0}}, rd_bank} : '0;
    end

    assert_cs_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && mem_cs));

    assert_low_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[ADDR_W-1:0] == cpu_addr);

    assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && cpu_rnw) |-> (reg_rdata == '0));
endmodule

// File: tb/bank_ctrl_front_tb.sv
module bank_ctrl_front_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_rnw;
    logic        cpu_sync;
    logic        ind_y_data;
    logic [19:0] phys_addr;
    logic        reg_sel;
    logic        mem_cs;
    logic [7:0]  reg_rdata;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_exec;
    logic [3:0] m_far;

    always #5 clk = ~clk;

    bank_ctrl_front u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rnw(cpu_rnw), .cpu_sync(cpu_sync), .ind_y_data(ind_y_data),
        .phys_addr(phys_addr), .reg_sel(reg_sel), .mem_cs(mem_cs),
        .reg_rdata(reg_rdata)
    );

    function automatic logic exp_far(input logic s, input logic f);
        return f && !s;
    endfunction

    function automatic logic exp_sel(input logic [15:0] a, input logic s, input logic f);
        return (a[15:1] == 15'd0) && !exp_far(s, f);
    endfunction

    function automatic logic [19:0] exp_phys(input logic [15:0] a, input logic s, input logic f);
        return {(exp_far(s, f) ? m_far : m_exec), a};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic s, input logic f, input logic r);
        if (exp_sel(a, s, f) && r) return {4'd0, (a[0] ? m_far : m_exec)};
        return 8'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check before posedge, update model after it.
    task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic r,
                       input logic s, input logic f, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rnw = r; cpu_sync = s; ind_y_data = f;
        #2;
        check({tag, " R2/R4 phys"}, 32'(phys_addr), 32'(exp_phys(a, s, f)));
        check({tag, " R3 reg_sel"}, 32'(reg_sel), 32'(exp_sel(a, s, f)));
        check({tag, " R9 mem_cs"}, 32'(mem_cs), 32'(!exp_sel(a, s, f)));
        check({tag, " R8 rdata"}, 32'(reg_rdata), 32'(exp_rd(a, s, f, r)));
        @(posedge clk);
        if (exp_sel(a, s, f) && !r) begin
            if (a[0]) m_far = d[3:0]; else m_exec = d[3:0];
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; cpu_addr = 16'h1234; cpu_wdata = 8'h00;
        cpu_rnw = 1'b1; cpu_sync = 1'b0; ind_y_data = 1'b0;
        m_exec = 4'hF; m_far = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values seen through the ports
        cyc(16'h8000, 8'h00, 1'b1, 1'b1, 1'b0, "R1 fetch");
        check("R1 exec bank", 32'(phys_addr[19:16]), 32'hF);
        cyc(16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, "R1 read exec");
        cyc(16'h0001, 8'h00, 1'b1, 1'b0, 1'b0, "R1 read far");

        // R6: load both registers, then observe the effect
        cyc(16'h0000, 8'hA3, 1'b0, 1'b0, 1'b0, "R6 wr exec");
        cyc(16'h0001, 8'h57, 1'b0, 1'b0, 1'b0, "R6 wr far");
        cyc(16'h4000, 8'h00, 1'b1, 1'b0, 1'b0, "R6 ordinary uses exec");
        check("R6 exec applied", 32'(phys_addr[19:16]), 32'h3);
        cyc(16'h4000, 8'h00, 1'b1, 1'b0, 1'b1, "R4 far data");
        check("R4 far applied", 32'(phys_addr[19:16]), 32'h7);

        // R5: sync wins over the indirect flag
        cyc(16'h0000, 8'h00, 1'b1, 1'b1, 1'b1, "R5 sync+flag low addr");
        check("R5 sel on sync", 32'(reg_sel), 32'h1);

        // R7: far-data write to 0x0000/0x0001 reaches memory, registers unchanged
        cyc(16'h0000, 8'h0C, 1'b0, 1'b0, 1'b1, "R7 far wr 0");
        cyc(16'h0001, 8'h0D, 1'b0, 1'b0, 1'b1, "R7 far wr 1");
        cyc(16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, "R7 readback exec");
        check("R7 exec intact", 32'(reg_rdata), 32'h03);
        cyc(16'h0001, 8'h00, 1'b1, 1'b0, 1'b0, "R7 readback far");
        check("R7 far intact", 32'(reg_rdata), 32'h07);

        // R3: neighbours of the window never select
        cyc(16'h0002, 8'hFF, 1'b0, 1'b0, 1'b0, "R3 addr 2");
        cyc(16'hFFFF, 8'hFF, 1'b0, 1'b0, 1'b0, "R3 addr FFFF");

        // Random mix biased toward the register window
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            logic [31:0] p;
            p = $urandom;
            a = (p[2:0] < 3'd4) ? {15'd0, p[3]} : p[31:16];
            cyc(a, 8'($urandom), p[4], p[5] & p[6], p[7], "RND");
        end

        // Final reset check: R1 again after traffic
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        m_exec = 4'hF; m_far = 4'hF;
        cyc(16'h0001, 8'h00, 1'b1, 1'b0, 1'b0, "R1 post-reset far");
        check("R1 far reset", 32'(reg_rdata), 32'h0F);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule